// File: doc/BRIEF.md
# MDIO Management Frame Responder

This block is the PHY end of a management link that software drives bit by bit. The host owns a four-bit control word. Each write to that word sets the clock, data-out and output-enable lines. The block watches for the clock line to go from 0 to 1 between two successive writes, and each such transition moves one serial bit into it. A frame starts once the block has seen a long run of ones. The header that follows names an operation and a register. For a read, the block returns the addressed register one bit per clock rise on the data-in line, and the host samples that line in the control word. For a write, the block consumes the data bits and throws them away.

The responder holds a bank of sixteen-bit PHY registers. After reset every one of them reads as zero, except two identifier registers that keep fixed values. The block only models the protocol. It does not model open-drain electrical behaviour, and it gives the registers no meaning beyond their reset contents.

Top module: `mdio_frame_responder`

## Requirements
- R1: The control word holds data-out at bit 0, data-in at bit 1, output-enable at bit 2 and the management clock at bit 3. After a host write, bits 0, 2 and 3 of `ctrl_q` show the written values from the clock edge that accepts the write.
- R2: Data-in (bit 1) cannot be set by the host. A host write leaves bit 1 at the value the block gives it.
- R3: A serial bit is taken only when a host write sets bit 3 to 1 and the previous written value of bit 3 was 0. Repeated writes with bit 3 held at 1 take no bits.
- R4: The bit taken is 1 only when both data-out and output-enable are 1 in that write. Otherwise it is 0.
- R5: The block locks onto a frame only after 32 consecutive one bits. The next 16 bits form the header. A frame preceded by only 31 ones is not answered.
- R6: The header is read MSB first as start[15:14], opcode[13:12], PHY address[11:7], register address[6:2] and turnaround[1:0]. A read is start 01, opcode 10 and turnaround bit 0 equal to 0. Turnaround bit 1 does not matter for a read.
- R7: On a valid read, each of the next 16 clock rises puts one bit of the addressed register on data-in, MSB first. Data-in changes in the same cycle that `ctrl_q` takes the rising write.
- R8: A write is start 01, opcode 01 and turnaround 10. The block takes 16 data bits, leaves data-in untouched while doing so, and then answers a new frame.
- R9: Any other header sends the block back to idle, and data-in does not change during the bits that follow.
- R10: After reset, `ctrl_q` is 0, register 2 reads 0x0022, register 3 reads 0x161A and all other registers read 0.
- R11: Writes to PHY registers are discarded. A read after a write returns the reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_wr | input | 1 | Host write strobe for the control word, one cycle per write |
| host_wdata | input | 4 | Written control value (bit 1 ignored) |
| ctrl_q | output | 4 | Current control word, data-in supplied by the block |

## Verification
Every result appears on `ctrl_q` at the clock edge that accepts the host write. The control bits and any new data-in bit are both due exactly one cycle after the strobe is driven. The bench drives each write on a falling edge and removes the strobe on the next falling edge. It samples `ctrl_q` at that point, half a cycle after the capturing edge, so every read bit is read in the cycle it is driven. After reset is released, the bench waits several cycles before the first write, to cover the two-stage release.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;
  // control word bit positions
  localparam int CB_DO  = 0;
  localparam int CB_DI  = 1;
  localparam int CB_OE  = 2;
  localparam int CB_CLK = 3;
  localparam int CTRL_W = 4;

  // header field positions (MSB-first serial order)
  localparam int HF_ST_LSB = 14;
  localparam int HF_OP_LSB = 12;
  localparam int HF_RA_LSB = 2;
  localparam int HF_TA_LSB = 0;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] TA_WRITE   = 2'b10;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_READ  = 2'd1,
    FS_WRITE = 2'd2
  } frame_state_e;
endpackage

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
  import mdio_resp_pkg::*;
#(
  parameter int SHIFT_W = 32,
  parameter int HDR_W   = 16,
  parameter int REG_AW  = 5,
  localparam int CNT_W  = $clog2(SHIFT_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic [REG_AW-1:0] hdr_reg_addr,
  output logic              rd_load,
  output logic              rd_shift,
  output frame_state_e      state_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [SHIFT_W-2:0] shift_q;
  logic               act_q;
  logic [SHIFT_W-1:0] shift_d;
  logic               sync_hit;
  logic [CNT_W-1:0]   cnt_eff;
  logic               act_eff;
  logic               at_hdr;
  logic               at_end;
  logic               in_data;
  frame_state_e       st_dec;
  frame_state_e       st_eff;
  frame_state_e       state_d;
  logic [CNT_W-1:0]   cnt_d;
  logic               act_d;

  always_comb begin
    shift_d  = {shift_q, bit_in};
    sync_hit = &shift_d;
    cnt_eff  = sync_hit ? CNT_W'(SHIFT_W) : cnt_q;
    act_eff  = sync_hit | act_q;
    at_hdr   = act_eff && (cnt_eff == CNT_W'(HDR_W));
    at_end   = act_eff && (cnt_eff == '0);
    in_data  = act_eff && (cnt_eff < CNT_W'(HDR_W));

    if (shift_d[HF_ST_LSB +: 2] == START_CODE &&
        shift_d[HF_OP_LSB +: 2] == OP_WRITE &&
        shift_d[HF_TA_LSB +: 2] == TA_WRITE)
      st_dec = FS_WRITE;
    else if (shift_d[HF_ST_LSB +: 2] == START_CODE &&
             shift_d[HF_OP_LSB +: 2] == OP_READ &&
             !shift_d[HF_TA_LSB])
      st_dec = FS_READ;
    else
      st_dec = FS_IDLE;

    st_eff       = at_hdr ? st_dec : state_q;
    hdr_reg_addr = shift_d[HF_RA_LSB +: REG_AW];
    rd_load      = bit_stb && at_hdr && (st_dec == FS_READ);
    rd_shift     = bit_stb && in_data && (st_eff == FS_READ);

    state_d = at_end ? FS_IDLE : st_eff;
    act_d   = act_eff && !at_end;
    cnt_d   = act_d ? (cnt_eff - 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      state_q <= FS_IDLE;
    end else if (bit_stb) begin
      shift_q <= shift_d[SHIFT_W-2:0];
      act_q   <= act_d;
      cnt_q   <= cnt_d;
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs #(
  parameter int          NREG     = 32,
  parameter int          DW       = 16,
  parameter int          ID_A_IDX = 2,
  parameter logic [15:0] ID_A_VAL = 16'h0022,
  parameter int          ID_B_IDX = 3,
  parameter logic [15:0] ID_B_VAL = 16'h161A,
  localparam int         AW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] cells [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    localparam logic [DW-1:0] INIT = (i == ID_A_IDX) ? DW'(ID_A_VAL) :
                                     (i == ID_B_IDX) ? DW'(ID_B_VAL) : '0;
    logic [DW-1:0] cell_q;
    // no write path: host writes are discarded
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= INIT;
    end
    assign cells[i] = cell_q;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/mdio_read_shifter.sv
module mdio_read_shifter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          shift,
  output logic          msb_o
);
  logic [DW-1:0] buf_q;
  logic [DW-1:0] buf_d;

  always_comb begin
    buf_d = buf_q;
    if (load)       buf_d = load_data;
    else if (shift) buf_d = {buf_q[DW-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              buf_q <= '0;
    else if (load || shift)  buf_q <= buf_d;
  end

  assign msb_o = buf_q[DW-1];
endmodule

// File: rtl/mdio_frame_responder.sv
module mdio_frame_responder
  import mdio_resp_pkg::*;
#(
  parameter int          SHIFT_W  = 32,
  parameter int          HDR_W    = 16,
  parameter int          NREG     = 32,
  parameter int          RDW      = 16,
  parameter logic [15:0] ID_A_VAL = 16'h0022,
  parameter logic [15:0] ID_B_VAL = 16'h161A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic [3:0] host_wdata,
  output logic [3:0] ctrl_q
);
  localparam int REG_AW = $clog2(NREG);
  localparam int CNT_W  = $clog2(SHIFT_W) + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              clk_prev_q;
  logic              clk_prev_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic              bit_stb;
  logic              bit_in;
  logic              di_d;
  logic [REG_AW-1:0] hdr_reg_addr;
  logic              rd_load;
  logic              rd_shift;
  logic              rd_msb;
  logic [RDW-1:0]    rd_data;
  frame_state_e      fsm_state;
  logic [CNT_W-1:0]  bit_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    bit_stb    = host_wr && host_wdata[CB_CLK] && !clk_prev_q;
    bit_in     = host_wdata[CB_DO] && host_wdata[CB_OE];
    di_d       = rd_shift ? rd_msb : ctrl_q[CB_DI];
    clk_prev_d = host_wr ? host_wdata[CB_CLK] : clk_prev_q;
    ctrl_d     = ctrl_q;
    if (host_wr) begin
      ctrl_d         = host_wdata;
      ctrl_d[CB_DI]  = di_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q     <= '0;
      clk_prev_q <= 1'b0;
    end else if (host_wr) begin
      ctrl_q     <= ctrl_d;
      clk_prev_q <= clk_prev_d;
    end
  end

  mdio_frame_decoder #(
    .SHIFT_W (SHIFT_W),
    .HDR_W   (HDR_W),
    .REG_AW  (REG_AW)
  ) u_dec (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .bit_stb      (bit_stb),
    .bit_in       (bit_in),
    .hdr_reg_addr (hdr_reg_addr),
    .rd_load      (rd_load),
    .rd_shift     (rd_shift),
    .state_q      (fsm_state),
    .cnt_q        (bit_cnt)
  );

  mdio_phy_regs #(
    .NREG     (NREG),
    .DW       (RDW),
    .ID_A_IDX (2),
    .ID_A_VAL (ID_A_VAL),
    .ID_B_IDX (3),
    .ID_B_VAL (ID_B_VAL)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_addr (hdr_reg_addr),
    .rd_data (rd_data)
  );

  mdio_read_shifter #(
    .DW (RDW)
  ) u_rdsh (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (rd_load),
    .load_data (rd_data),
    .shift     (rd_shift),
    .msb_o     (rd_msb)
  );
endmodule

// File: rtl/mdio_frame_responder_chk.sv
module mdio_frame_responder_chk
  import mdio_resp_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int SHIFT_W = 32
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             host_wr,
  input logic [3:0]       host_wdata,
  input logic [3:0]       ctrl_q,
  input logic             clk_prev_q,
  input frame_state_e     fsm_state,
  input logic [CNT_W-1:0] bit_cnt
);
  // R1: written control bits appear one edge later
  assert_ctrl_follow_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    host_wr |=> (ctrl_q[CB_DO] == $past(host_wdata[CB_DO]) &&
                 ctrl_q[CB_OE] == $past(host_wdata[CB_OE]) &&
                 ctrl_q[CB_CLK] == $past(host_wdata[CB_CLK])));

  // R2: without a host write the control word holds
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(host_wr) |-> $stable(ctrl_q));

  // R3: data-in moves only on a rising clock write
  assert_di_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(host_wr && host_wdata[CB_CLK] && !clk_prev_q) |-> $stable(ctrl_q[CB_DI]));

  // R7: data-in changes only while a read is in progress
  assert_di_read_only_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctrl_q[CB_DI] != $past(ctrl_q[CB_DI])) |-> ($past(fsm_state) == FS_READ));

  // R8: a write frame never touches data-in
  assert_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(fsm_state) == FS_WRITE) |-> $stable(ctrl_q[CB_DI]));

  // R5: bit counter never exceeds the sync length
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    bit_cnt <= CNT_W'(SHIFT_W));
endmodule

bind mdio_frame_responder mdio_frame_responder_chk #(
  .CNT_W   ($clog2(SHIFT_W) + 1),
  .SHIFT_W (SHIFT_W)
) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .ctrl_q     (ctrl_q),
  .clk_prev_q (clk_prev_q),
  .fsm_state  (fsm_state),
  .bit_cnt    (bit_cnt)
);

// File: tb/mdio_frame_responder_test.sv
module mdio_frame_responder_test;
  logic       clk;
  logic       rst_n;
  logic       host_wr;
  logic [3:0] host_wdata;
  logic [3:0] ctrl_q;
  int checks;
  int errors;

  mdio_frame_responder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .ctrl_q     (ctrl_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // read vectors: {phy[4:0], reg[4:0], ta[1:0], expected[15:0]}
  localparam logic [27:0] RD_VEC [0:4] = '{
    {5'd0,  5'd2,  2'b00, 16'h0022},
    {5'd1,  5'd3,  2'b10, 16'h161A},
    {5'd31, 5'd0,  2'b00, 16'h0000},
    {5'd5,  5'd31, 2'b10, 16'h0000},
    {5'd9,  5'd3,  2'b00, 16'h161A}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] v);
    @(negedge clk);
    host_wr    = 1'b1;
    host_wdata = v;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  // bits: [3]=clock, [2]=output enable, [1]=data-in (ignored), [0]=data-out
  task automatic send_bit(input logic b, input logic oe);
    hwrite({1'b0, oe, 1'b0, b});
    hwrite({1'b1, oe, 1'b0, b});
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b1);
  endtask

  task automatic send_hdr(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] oe_mask);
    logic [15:0] h;
    h = {st, op, phy, ra, ta};
    for (int i = 15; i >= 0; i--) send_bit(h[i], oe_mask[i]);
  endtask

  task automatic collect(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      send_bit(1'b0, 1'b0);
      w[i] = ctrl_q[1];
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [15:0] h;
    logic di0;
    logic moved;
    checks = 0;
    errors = 0;
    host_wr = 1'b0;
    host_wdata = 4'h0;
    do_reset();

    // R10: reset value of the control word
    chk("R10 ctrl after reset", {12'h0, ctrl_q}, 16'h0);

    // R5: only 31 ones before a read header -> no answer
    preamble(31);
    send_hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 16'hFFFF);
    collect(w);
    chk("R5 short preamble ignored", w, 16'h0000);

    // R2: host cannot set data-in
    hwrite(4'b0010);
    chk("R2 di write ignored", {12'h0, ctrl_q}, 16'h0000);
    hwrite(4'b0111);
    chk("R2 di kept with other bits", {12'h0, ctrl_q}, 16'h0005);
    // R1: clock, oe, do placed at bits 3, 2, 0
    hwrite(4'b1011);
    chk("R1 ctrl bit positions", {12'h0, ctrl_q}, 16'h0009);

    // R6 R7 R10: table of read frames
    for (int k = 0; k < 5; k++) begin
      preamble(32);
      send_hdr(2'b01, 2'b10, RD_VEC[k][27:23], RD_VEC[k][22:18], RD_VEC[k][17:16], 16'hFFFF);
      collect(w);
      chk($sformatf("R6 R7 R10 read vector %0d", k), w, RD_VEC[k][15:0]);
    end

    // R3: extra writes with clock held high take no bits
    preamble(32);
    h = {2'b01, 2'b10, 5'd4, 5'd3, 2'b00};
    for (int i = 15; i >= 0; i--) begin
      send_bit(h[i], 1'b1);
      hwrite(4'b1100);
      hwrite(4'b1101);
    end
    collect(w);
    chk("R3 level writes ignored", w, 16'h161A);

    // R4: register address LSB sent with oe low becomes 0 -> reg 2
    preamble(32);
    send_hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 16'hFFFB);
    collect(w);
    chk("R4 bit needs do and oe", w, 16'h0022);

    // R9: invalid headers leave data-in untouched
    preamble(32);
    send_hdr(2'b01, 2'b10, 5'd0, 5'd2, 2'b01, 16'hFFFF);
    collect(w);
    chk("R9 read with ta bit0 set", w, 16'h0000);
    preamble(32);
    send_hdr(2'b00, 2'b10, 5'd0, 5'd3, 2'b00, 16'hFFFF);
    collect(w);
    chk("R9 bad start code", w, 16'h0000);

    // R8: write frame consumes data without touching data-in
    preamble(32);
    send_hdr(2'b01, 2'b01, 5'd0, 5'd3, 2'b10, 16'hFFFF);
    di0 = ctrl_q[1];
    moved = 1'b0;
    for (int i = 0; i < 16; i++) begin
      send_bit(1'b1, 1'b1);
      if (ctrl_q[1] !== di0) moved = 1'b1;
    end
    chk("R8 di quiet during write", {15'h0, moved}, 16'h0);
    // R11: value unchanged after the write
    preamble(32);
    send_hdr(2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 16'hFFFF);
    collect(w);
    chk("R11 reg3 after write", w, 16'h161A);
    preamble(32);
    send_hdr(2'b01, 2'b01, 5'd0, 5'd2, 2'b10, 16'hFFFF);
    for (int i = 0; i < 16; i++) send_bit(1'b0, 1'b1);
    preamble(32);
    send_hdr(2'b01, 2'b10, 5'd0, 5'd2, 2'b10, 16'hFFFF);
    collect(w);
    chk("R8 R11 reg2 after write", w, 16'h0022);

    // R10: reset in the middle of activity
    hwrite(4'b1101);
    do_reset();
    chk("R10 ctrl after second reset", {12'h0, ctrl_q}, 16'h0);
    preamble(32);
    send_hdr(2'b01, 2'b10, 5'd2, 5'd3, 2'b00, 16'hFFFF);
    collect(w);
    chk("R10 reg3 after second reset", w, 16'h161A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule